// File: doc/BRIEF.md
# Control-Word Driven 8-bit ALU

This block is an 8-bit arithmetic and logic unit for a microcoded processor. It has no opcode input. Each cycle, a set of independent control lines builds the operation. Some lines choose the operands. Others enable one or more result paths: adder, AND, OR, XOR and shifter. Further lines shape the adder carry-in and the inversion of the right operand, and pick the shifter mode. The last group decides which registers and flags capture the outcome. A sequencer outside the block drives these lines.

The block holds five result registers, called A, B, C, T and U, plus a carry flag and negative/zero flags. Both operand selectors read the registers. The right selector can also pass a byte from outside the block, or one of four fixed constants. The result bus is combinational from the current registers and controls. Registers and flags change only on the rising clock edge. Subtract, increment, decrement, add-with-carry and subtract-with-borrow are not separate operations. Each one is the adder with a particular combination of inversion and carry-in lines.

Top module: `cw_alu`

## Requirements
- R1: Left select bits `lsel[0..4]` choose A, B, C, T, U. Several asserted bits give the bitwise OR of those registers, and no asserted bit gives 0.
- R2: Right select bits work the same way, ORing every selected source. Bits 0..4 choose A, B, C, T, U. Bit 5 chooses `ext_byte`. Bits 6, 7, 8 and 9 choose the constants 0x01, 0x02, 0xFF and 0xFE.
- R3: The adder path yields (lhs + rop + cin) mod 256.
  - rop is ~rhs when `rinv` is set, and rhs otherwise.
  - cin is `cin_one` OR (`cin_carry` AND the carry flag).
  - As a result, `rinv` with `cin_one` gives lhs − rhs, and `rinv` with `cin_carry` gives lhs − rhs − 1 + carry.
- R4: At a rising edge the carry flag loads bit 8 of the 9-bit adder sum only when `save_carry` and `fn_add` are both high. Logic-only and shift-only words leave carry unchanged even when `save_carry` is high.
- R5: `fn_and`, `fn_or` and `fn_xor` yield lhs&rhs, lhs|rhs and lhs^rhs.
- R6: `fn_shift` acts on lhs. The shift mode comes from the three modifier lines:
  - `sh_right`=0, `sh_rot`=0: shift left, filling with 0. `sh_arith` has no effect in this case.
  - `sh_right`=0, `sh_rot`=1: rotate left.
  - `sh_right`=1, `sh_rot`=0, `sh_arith`=0: shift right, filling with 0.
  - `sh_right`=1, `sh_rot`=0, `sh_arith`=1: shift right, copying bit 7.
  - `sh_right`=1, `sh_rot`=1: rotate right. Rotate takes priority over `sh_arith`.
  - Rotates never pass through the carry flag.
- R7: With several function enables high, the result is the bitwise OR of the enabled path outputs. With none high, the result is 0.
- R8: When `save_nz` is high at a rising edge, `neg` takes result bit 7 and `zero` takes (result == 0). Otherwise both flags hold their values.
- R9: Register i (A=0, B=1, C=2, T=3, U=4, held in `regs[8i+7:8i]`) loads the result at a rising edge only when `save_en[i]` is high. Several registers can load in the same edge, and the rest hold their values.
- R10: When `rst_n` is low at a rising edge, all registers and all flags clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| lsel | input | 5 | Left operand source lines (A,B,C,T,U) |
| rsel | input | 10 | Right operand source lines (A,B,C,T,U,ext,+1,+2,-1,-2) |
| ext_byte | input | 8 | External byte for the right operand |
| fn_add | input | 1 | Enable adder path |
| fn_and | input | 1 | Enable AND path |
| fn_or | input | 1 | Enable OR path |
| fn_xor | input | 1 | Enable XOR path |
| fn_shift | input | 1 | Enable shifter path |
| rinv | input | 1 | Invert right operand at the adder |
| cin_one | input | 1 | Force adder carry-in to 1 |
| cin_carry | input | 1 | Feed the carry flag into the adder carry-in |
| sh_right | input | 1 | Shifter direction right |
| sh_rot | input | 1 | Shifter rotates |
| sh_arith | input | 1 | Right shift copies the sign bit |
| save_carry | input | 1 | Allow carry flag capture |
| save_nz | input | 1 | Capture negative/zero flags |
| save_en | input | 5 | Per-register write lines (A,B,C,T,U) |
| result | output | 8 | Combinational result bus |
| carry | output | 1 | Carry flag |
| neg | output | 1 | Negative flag |
| zero | output | 1 | Zero flag |
| regs | output | 40 | Register contents, A in the low byte, U in the high byte |

## Verification
The hardest cases to reach are the ones that depend on the carry flag. These are add-with-carry, subtract-with-borrow, and the rule that logic and shift words must not disturb carry. Each needs carry in a known state before the operation runs. The stimulus first issues a separate control word: 0xFF plus a carry-in of 0 or 1 from the constant lines, with no register writes. This sets carry to a chosen value. The operation under test then follows with `save_carry` still high, so any leak into the carry flag would show up. The operand sweep covers every left value against a set of boundary right values, and the select lines and function enables are swept over all their combinations.

// File: rtl/cw_alu_pkg.sv
`timescale 1ns/1ps
// Shared types for the control-word ALU.
// Assumes: the fixed constant set at the right operand has four entries.
package cw_alu_pkg;

    localparam int NUM_CONST = 4;

    // Decoded control lines that steer the combinational core.
    typedef struct packed {
        logic op_add;
        logic op_and;
        logic op_or;
        logic op_xor;
        logic op_shift;
        logic rinv;
        logic cin_one;
        logic cin_carry;
        logic sh_right;
        logic sh_rot;
        logic sh_arith;
    } alu_fn_t;

    typedef enum logic [2:0] {
        SH_LSL,
        SH_ROL,
        SH_LSR,
        SH_ROR,
        SH_ASR
    } shift_mode_e;

    // Collapse the three shifter modifiers into one mode; rotate beats arith.
    function automatic shift_mode_e decode_shift(input logic right,
                                                 input logic rot,
                                                 input logic arith);
        shift_mode_e m;
        if (!right)
            m = rot ? SH_ROL : SH_LSL;
        else if (rot)
            m = SH_ROR;
        else
            m = arith ? SH_ASR : SH_LSR;
        return m;
    endfunction

endpackage

// File: rtl/cw_alu_opsel.sv
`timescale 1ns/1ps
// Operand selection for both ALU inputs.
// Every select line gates one source onto a wired-OR bus, so several
// asserted lines merge bitwise and no asserted line yields zero.
// Assumes: register bank arrives packed, register 0 in the low bits.
module cw_alu_opsel
    import cw_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 5
) (
    input  logic [NREG*DATA_W-1:0]      regs,
    input  logic [NREG-1:0]             lsel,
    input  logic [NREG+NUM_CONST:0]     rsel,
    input  logic [DATA_W-1:0]           ext_byte,
    output logic [DATA_W-1:0]           lhs,
    output logic [DATA_W-1:0]           rhs
);

    localparam int RSEL_W = NREG + 1 + NUM_CONST;
    localparam int EXT_IX = NREG;

    logic [DATA_W-1:0] lsrc [NREG];
    logic [DATA_W-1:0] rsrc [RSEL_W];

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_regsrc
            assign lsrc[g] = regs[g*DATA_W +: DATA_W];
            assign rsrc[g] = regs[g*DATA_W +: DATA_W];
        end
    endgenerate

    assign rsrc[EXT_IX]     = ext_byte;
    assign rsrc[EXT_IX + 1] = DATA_W'(1);
    assign rsrc[EXT_IX + 2] = DATA_W'(2);
    assign rsrc[EXT_IX + 3] = '1;
    assign rsrc[EXT_IX + 4] = ~DATA_W'(1);

    // Left bus: OR of every gated register.
    always_comb begin
        lhs = '0;
        for (int i = 0; i < NREG; i++)
            if (lsel[i]) lhs = lhs | lsrc[i];
    end

    // Right bus: OR of every gated register, external byte or constant.
    always_comb begin
        rhs = '0;
        for (int i = 0; i < RSEL_W; i++)
            if (rsel[i]) rhs = rhs | rsrc[i];
    end

endmodule

// File: rtl/cw_alu_core.sv
`timescale 1ns/1ps
// Combinational datapath: adder, bitwise paths and shifter.
// Enabled path outputs are ORed onto the result bus.
// Assumes: DATA_W >= 2; carry_flag is the registered carry.
module cw_alu_core
    import cw_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    input  alu_fn_t           fn,
    input  logic              carry_flag,
    output logic [DATA_W-1:0] result,
    output logic              cout
);

    logic [DATA_W-1:0] rop;
    logic              cin;
    logic [DATA_W:0]   sum;
    logic [DATA_W-1:0] sh_v;
    shift_mode_e       mode;

    // Adder with optional right inversion and selectable carry-in.
    always_comb begin
        rop = fn.rinv ? ~rhs : rhs;
        cin = fn.cin_one | (fn.cin_carry & carry_flag);
        sum = {1'b0, lhs} + {1'b0, rop} + {{DATA_W{1'b0}}, cin};
    end

    assign cout = sum[DATA_W];
    assign mode = decode_shift(fn.sh_right, fn.sh_rot, fn.sh_arith);

    // Shifter on the left operand; rotates stay within the word.
    always_comb begin
        case (mode)
            SH_LSL:  sh_v = {lhs[DATA_W-2:0], 1'b0};
            SH_ROL:  sh_v = {lhs[DATA_W-2:0], lhs[DATA_W-1]};
            SH_LSR:  sh_v = {1'b0, lhs[DATA_W-1:1]};
            SH_ROR:  sh_v = {lhs[0], lhs[DATA_W-1:1]};
            SH_ASR:  sh_v = {lhs[DATA_W-1], lhs[DATA_W-1:1]};
            default: sh_v = lhs;
        endcase
    end

    // Wired-OR merge of all enabled paths.
    always_comb begin
        result = '0;
        if (fn.op_add)   result = result | sum[DATA_W-1:0];
        if (fn.op_and)   result = result | (lhs & rhs);
        if (fn.op_or)    result = result | (lhs | rhs);
        if (fn.op_xor)   result = result | (lhs ^ rhs);
        if (fn.op_shift) result = result | sh_v;
    end

endmodule

// File: rtl/cw_alu_state.sv
`timescale 1ns/1ps
// Result registers and flags with per-target write lines.
// Assumes: synchronous active-low reset; carry_we already qualified.
module cw_alu_state #(
    parameter int DATA_W = 8,
    parameter int NREG   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DATA_W-1:0]      result,
    input  logic                   cout,
    input  logic [NREG-1:0]        reg_we,
    input  logic                   carry_we,
    input  logic                   nz_we,
    output logic [NREG*DATA_W-1:0] regs_q,
    output logic                   carry_q,
    output logic                   neg_q,
    output logic                   zero_q
);

    logic [DATA_W-1:0] bank [NREG];

    // Register bank: each entry loads the result under its own line.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)
                bank[i] <= '0;
            else if (reg_we[i])
                bank[i] <= result;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_pack
            assign regs_q[g*DATA_W +: DATA_W] = bank[g];

            // R9: unselected register keeps its value.
            a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !reg_we[g] |=> $stable(bank[g]));
            // R9: selected register captures the result bus.
            a_r9_write: assert property (@(posedge clk) disable iff (!rst_n)
                reg_we[g] |=> bank[g] == $past(result));
        end
    endgenerate

    // Carry flag capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_q <= 1'b0;
        else if (carry_we)
            carry_q <= cout;
    end

    // Negative and zero flag capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q  <= 1'b0;
            zero_q <= 1'b0;
        end else if (nz_we) begin
            neg_q  <= result[DATA_W-1];
            zero_q <= (result == '0);
        end
    end

    a_r8_nz_capture: assert property (@(posedge clk) disable iff (!rst_n)
        nz_we |=> (zero_q == ($past(result) == '0)) && (neg_q == $past(result[DATA_W-1])));
    a_r8_nz_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !nz_we |=> $stable(neg_q) && $stable(zero_q));

endmodule

// File: rtl/cw_alu.sv
`timescale 1ns/1ps
// Control-word ALU top: operand select, datapath and state.
// The operation is whatever the control lines combine to; no opcode.
// Assumes: controls are stable around the rising clock edge.
module cw_alu
    import cw_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NREG-1:0]        lsel,
    input  logic [NREG+NUM_CONST:0] rsel,
    input  logic [DATA_W-1:0]      ext_byte,
    input  logic                   fn_add,
    input  logic                   fn_and,
    input  logic                   fn_or,
    input  logic                   fn_xor,
    input  logic                   fn_shift,
    input  logic                   rinv,
    input  logic                   cin_one,
    input  logic                   cin_carry,
    input  logic                   sh_right,
    input  logic                   sh_rot,
    input  logic                   sh_arith,
    input  logic                   save_carry,
    input  logic                   save_nz,
    input  logic [NREG-1:0]        save_en,
    output logic [DATA_W-1:0]      result,
    output logic                   carry,
    output logic                   neg,
    output logic                   zero,
    output logic [NREG*DATA_W-1:0] regs
);

    logic [DATA_W-1:0] lhs;
    logic [DATA_W-1:0] rhs;
    logic              cout;
    logic              carry_we;
    alu_fn_t           fn;

    // Gather loose control lines into the core's control struct.
    always_comb begin
        fn.op_add    = fn_add;
        fn.op_and    = fn_and;
        fn.op_or     = fn_or;
        fn.op_xor    = fn_xor;
        fn.op_shift  = fn_shift;
        fn.rinv      = rinv;
        fn.cin_one   = cin_one;
        fn.cin_carry = cin_carry;
        fn.sh_right  = sh_right;
        fn.sh_rot    = sh_rot;
        fn.sh_arith  = sh_arith;
    end

    // Carry is only meaningful when the adder drives the bus.
    assign carry_we = save_carry & fn_add;

    cw_alu_opsel #(.DATA_W(DATA_W), .NREG(NREG)) u_opsel (
        .regs     (regs),
        .lsel     (lsel),
        .rsel     (rsel),
        .ext_byte (ext_byte),
        .lhs      (lhs),
        .rhs      (rhs)
    );

    cw_alu_core #(.DATA_W(DATA_W)) u_core (
        .lhs        (lhs),
        .rhs        (rhs),
        .fn         (fn),
        .carry_flag (carry),
        .result     (result),
        .cout       (cout)
    );

    cw_alu_state #(.DATA_W(DATA_W), .NREG(NREG)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .result   (result),
        .cout     (cout),
        .reg_we   (save_en),
        .carry_we (carry_we),
        .nz_we    (save_nz),
        .regs_q   (regs),
        .carry_q  (carry),
        .neg_q    (neg),
        .zero_q   (zero)
    );

    // R4: words without the adder never disturb carry.
    a_r4_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(fn_add && save_carry) |=> $stable(carry));
    // R4: plain add sets carry exactly when the sum overflows.
    a_r4_carry_add: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_add && save_carry && !rinv && !cin_one && !cin_carry)
        |=> carry == ($past(lhs) > ~$past(rhs)));
    // R3: invert plus forced carry-in is two's complement subtraction.
    a_r3_subtract: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_add && !fn_and && !fn_or && !fn_xor && !fn_shift &&
         rinv && cin_one && !cin_carry) |-> result == DATA_W'(lhs - rhs));
    // R7: no enabled path leaves the bus at zero.
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(fn_add || fn_and || fn_or || fn_xor || fn_shift) |-> result == '0);

endmodule

// File: tb/test_cw_alu.sv
`timescale 1ns/1ps
module test_cw_alu;

    localparam time CLK_HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  lsel = '0;
    logic [9:0]  rsel = '0;
    logic [7:0]  ext_byte = '0;
    logic        fn_add = 0, fn_and = 0, fn_or = 0, fn_xor = 0, fn_shift = 0;
    logic        rinv = 0, cin_one = 0, cin_carry = 0;
    logic        sh_right = 0, sh_rot = 0, sh_arith = 0;
    logic        save_carry = 0, save_nz = 0;
    logic [4:0]  save_en = '0;
    logic [7:0]  result;
    logic        carry, neg, zero;
    logic [39:0] regs;

    int n_vec = 0;
    int n_fail = 0;
    int m_reg [5];
    int m_c, m_n, m_z;
    int blist [8];

    always #CLK_HALF clk = ~clk;

    cw_alu i_cw_alu (
        .clk(clk), .rst_n(rst_n), .lsel(lsel), .rsel(rsel), .ext_byte(ext_byte),
        .fn_add(fn_add), .fn_and(fn_and), .fn_or(fn_or), .fn_xor(fn_xor),
        .fn_shift(fn_shift), .rinv(rinv), .cin_one(cin_one), .cin_carry(cin_carry),
        .sh_right(sh_right), .sh_rot(sh_rot), .sh_arith(sh_arith),
        .save_carry(save_carry), .save_nz(save_nz), .save_en(save_en),
        .result(result), .carry(carry), .neg(neg), .zero(zero), .regs(regs)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_ctl();
        lsel = '0; rsel = '0; ext_byte = '0;
        fn_add = 0; fn_and = 0; fn_or = 0; fn_xor = 0; fn_shift = 0;
        rinv = 0; cin_one = 0; cin_carry = 0;
        sh_right = 0; sh_rot = 0; sh_arith = 0;
        save_carry = 0; save_nz = 0; save_en = '0;
    endtask

    task automatic check_state();
        for (int i = 0; i < 5; i++)
            check("R9 register", int'(regs[i*8 +: 8]), m_reg[i]);
        check("R4 carry", int'(carry), m_c);
        check("R8 neg", int'(neg), m_n);
        check("R8 zero", int'(zero), m_z);
    endtask

    // Apply the control word set at this negedge, check bus, then state.
    task automatic cycle(input string req);
        int lv, rv, rop, cin, sum, sv, exp, co;
        lv = 0; rv = 0;
        for (int i = 0; i < 5; i++) begin
            if (lsel[i]) lv = lv | m_reg[i];
            if (rsel[i]) rv = rv | m_reg[i];
        end
        if (rsel[5]) rv = rv | int'(ext_byte);
        if (rsel[6]) rv = rv | 1;
        if (rsel[7]) rv = rv | 2;
        if (rsel[8]) rv = rv | 255;
        if (rsel[9]) rv = rv | 254;
        rop = rinv ? 255 - rv : rv;
        cin = (cin_one || (cin_carry && m_c != 0)) ? 1 : 0;
        sum = lv + rop + cin;
        co  = (sum >= 256) ? 1 : 0;
        if (!sh_right) sv = sh_rot ? ((lv * 2) % 256 + lv / 128) : (lv * 2) % 256;
        else if (sh_rot) sv = lv / 2 + (lv % 2) * 128;
        else if (sh_arith) sv = lv / 2 + ((lv >= 128) ? 128 : 0);
        else sv = lv / 2;
        exp = 0;
        if (fn_add)   exp = exp | (sum % 256);
        if (fn_and)   exp = exp | (lv & rv);
        if (fn_or)    exp = exp | (lv | rv);
        if (fn_xor)   exp = exp | (lv ^ rv);
        if (fn_shift) exp = exp | sv;
        #2;
        check(req, int'(result), exp);
        @(posedge clk);
        #2;
        for (int i = 0; i < 5; i++) if (save_en[i]) m_reg[i] = exp;
        if (save_nz) begin
            m_n = (exp >= 128) ? 1 : 0;
            m_z = (exp == 0) ? 1 : 0;
        end
        if (save_carry && fn_add) m_c = co;
        check_state();
        @(negedge clk);
        clear_ctl();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        for (int i = 0; i < 5; i++) m_reg[i] = 0;
        m_c = 0; m_n = 0; m_z = 0;
        for (int i = 0; i < 5; i++) check("R10 reset reg", int'(regs[i*8 +: 8]), 0);
        check("R10 reset carry", int'(carry), 0);
        check("R10 reset neg", int'(neg), 0);
        check("R10 reset zero", int'(zero), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic load(input int idx, input int val);
        ext_byte = 8'(val); rsel = 10'b00_0010_0000; fn_add = 1; save_en = 5'(1 << idx);
        cycle("R2 load");
    endtask

    // Put the carry flag into a known state: 0xFF + cin.
    task automatic set_carry(input int c);
        rsel = 10'b01_0000_0000; fn_add = 1; cin_one = c[0]; save_carry = 1;
        cycle("R4 preset");
    endtask

    task automatic sweep_op(input int k);
        lsel = 5'b00001; rsel = 10'b00_0000_0010; save_en = 5'b00100;
        save_nz = 1; save_carry = 1;
        case (k)
            0: begin fn_add = 1; cycle("R3 add"); end
            1: begin fn_add = 1; cin_carry = 1; cycle("R3 add-with-carry"); end
            2: begin fn_add = 1; rinv = 1; cin_one = 1; cycle("R3 subtract"); end
            3: begin fn_add = 1; rinv = 1; cin_carry = 1; cycle("R3 subtract-with-borrow"); end
            4: begin fn_and = 1; cycle("R5 and"); end
            5: begin fn_or = 1; cycle("R5 or"); end
            6: begin fn_xor = 1; cycle("R5 xor"); end
            7: begin fn_add = 1; rsel = '0; cin_one = 1; cycle("R3 increment"); end
            default: begin fn_add = 1; rsel = '0; rinv = 1; cycle("R3 decrement"); end
        endcase
    endtask

    initial begin
        #(2 * CLK_HALF * 150000);
        n_fail++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        blist = '{0, 1, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA, 0};
        for (int i = 0; i < 5; i++) m_reg[i] = 0;
        m_c = 0; m_n = 0; m_z = 0;
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // R1: all left-select combinations over distinct register values.
        load(0, 8'h01); load(1, 8'h12); load(2, 8'h44); load(3, 8'h80); load(4, 8'h28);
        for (int m = 0; m < 32; m++) begin
            lsel = 5'(m); fn_add = 1; save_nz = 1;
            cycle("R1 left select");
        end
        // R2: all right-select combinations.
        for (int m = 0; m < 1024; m++) begin
            rsel = 10'(m); ext_byte = 8'h3C; fn_add = 1;
            cycle("R2 right select");
        end
        // R7: every combination of function enables.
        for (int m = 0; m < 32; m++) begin
            lsel = 5'b00010; rsel = 10'b00_0000_0100;
            fn_add = m[0]; fn_and = m[1]; fn_or = m[2]; fn_xor = m[3]; fn_shift = m[4];
            save_nz = 1;
            cycle("R7 merged paths");
        end

        // R3/R4/R5/R8: arithmetic and logic sweep with carry preset both ways.
        for (int a = 0; a < 256; a++) begin
            for (int bi = 0; bi < 8; bi++) begin
                int b;
                b = (bi == 7) ? (a * 7 + 3) % 256 : blist[bi];
                load(0, a);
                load(1, b);
                for (int k = 0; k < 9; k++) begin
                    set_carry((a + bi + k) % 2);
                    sweep_op(k);
                end
            end
        end

        // R6: shifter modes including modifier corners; carry must hold (R4).
        for (int a = 0; a < 256; a++) begin
            load(4, a);
            for (int md = 0; md < 8; md++) begin
                lsel = 5'b10000; fn_shift = 1; save_en = 5'b01000;
                save_nz = 1; save_carry = 1;
                sh_right = md[0]; sh_rot = md[1]; sh_arith = md[2];
                cycle("R6 shift");
            end
        end

        // R9: constants added with two registers written together.
        for (int a = 0; a < 256; a++) begin
            load(0, a);
            for (int k = 6; k < 10; k++) begin
                lsel = 5'b00001; rsel = 10'(1 << k); fn_add = 1;
                save_en = 5'b01010; save_carry = 1; save_nz = 1;
                cycle("R9 multi write");
            end
        end

        // R10: reset in the middle of activity.
        load(2, 8'hA5);
        set_carry(1);
        lsel = 5'b00100; fn_add = 1; save_nz = 1;
        cycle("R8 before reset");
        do_reset();
        check("R10 bus after reset", int'(result), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule